// File: doc/BRIEF.md
# Acquisition Ring Buffer with Interrupt Controller

This block is a two-sided circular store that sits between a sample-producing acquisition engine and a host processor. The engine pushes 16-bit samples, one per cycle at most, into the slot named by the producer (front) index. The host reads samples out of the storage window through a word-addressed register port. After draining a batch, it publishes how far it has consumed by writing its consumer (rear) index into a register. The storage depth is a parameter and need not be a power of two, so both indices wrap explicitly from `DEPTH-1` back to zero.

To find the number of words waiting, the host reads the front index and subtracts its own last position, adding `DEPTH` when the difference is negative. The block raises a sticky flag once the occupancy reaches a programmable fill threshold, which resets to half the depth. It also flags an overrun when a push would fill the last free slot, and it collects a hardware error strobe from the engine plus five events from neighbouring blocks. A mask register selects which flags drive the single interrupt line.

The host port is a request/ready interface with one control state machine. State `H_IDLE` accepts any request. A write completes there, and the machine stays in `H_IDLE`. An accepted read takes the transition `H_IDLE -> H_RESP`. `H_RESP` presents the read data with `host_rvalid` high for exactly one cycle, with `host_ready` low, and always returns `H_RESP -> H_IDLE`.

Top module: `acq_ring_top`

## Requirements
- R1: After reset the front and rear indices are 0, the status and mask registers are 0, the threshold register holds DEPTH/2 (integer division), and `irq` is low.
- R2: A push (`smp_valid` high, not an overrun) stores `smp_data` in the slot at the front index, and the front index advances by one, wrapping from DEPTH-1 to 0.
- R3: A push whose wrapped next front index equals the rear index is an overrun. The sample is dropped, the front index and the storage are unchanged, and status bit 1 is set.
- R4: Let B = 2^ceil(log2(DEPTH)). Reads at word address a < DEPTH return the stored sample. Reads at B+0, B+1, B+2, B+3 and B+4 return, zero-extended, the front index, rear index, threshold, mask and status. Every other address reads 0. Read data appears with `host_rvalid` in the cycle after the request is accepted.
- R5: A write to B+1 loads the rear index only when the written value is below DEPTH; larger values are ignored. Writes to B+0 and to the sample window change nothing.
- R6: Status bit 0 is set in the cycle after the occupancy, (front - rear) mod DEPTH, is at or above a non-zero threshold (written at B+2, low index bits). A threshold of 0 disables this flag.
- R7: A high `in_hw_err` sets status bit 2. `side_evt[k]` sets status bit 3+k, where bits 3 to 7 are output-empty, output software error, output hardware error, counter/timer done and command done.
- R8: Status bits are sticky. Writing a 1 to a bit at B+4 clears it, and a set condition in the same cycle wins over the clear.
- R9: `irq` is high exactly when some status bit is 1 and the matching mask bit (written at B+3) is 1. A mask of 0 holds `irq` low.
- R10: `host_ready` is high in `H_IDLE` and low in `H_RESP`. `H_RESP` lasts exactly one cycle and always returns to `H_IDLE`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Engine pushes a sample this cycle |
| smp_data | input | DATA_W | Sample value |
| in_hw_err | input | 1 | Engine hardware error strobe (status bit 2) |
| side_evt | input | 5 | Events for status bits 3 to 7 |
| host_req | input | 1 | Host request |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | clog2(DEPTH)+1 | Word address |
| host_wdata | input | DATA_W | Write data |
| host_ready | output | 1 | Request can be accepted |
| host_rvalid | output | 1 | Read data valid |
| host_rdata | output | DATA_W | Read data |
| irq | output | 1 | Interrupt line |

## Verification
The bench builds the block with DEPTH = 13 and DATA_W = 16. With that depth the reset threshold is 6, the registers sit at word 16, and the gap words 13 to 15 are exercised. A dozen pushes are enough to wrap the front index past zero and reach the last-free-slot overrun, which the 2003-deep default would need thousands of cycles to reach. A behavioural model built on integers and arrays predicts `irq`, the handshake and every read word each cycle, and directed reads check the boundary values.

// File: rtl/acq_ring_pkg.sv
package acq_ring_pkg;

    localparam int STAT_W      = 8;
    localparam int SIDE_W      = 5;
    localparam int ST_THRESH   = 0;
    localparam int ST_OVERRUN  = 1;
    localparam int ST_HW_ERR   = 2;
    localparam int ST_SIDE_LO  = 3;

    typedef enum logic [2:0] {
        REG_FRONT  = 3'd0,
        REG_REAR   = 3'd1,
        REG_THRESH = 3'd2,
        REG_MASK   = 3'd3,
        REG_STATUS = 3'd4
    } reg_sel_e;

    typedef enum logic {
        H_IDLE = 1'b0,
        H_RESP = 1'b1
    } host_state_e;

endpackage

// File: rtl/acq_ring_store.sv
module acq_ring_store #(
    parameter int DEPTH  = 2003,
    parameter int DATA_W = 16,
    parameter int IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] cells [DEPTH];

    // Port A belongs to the engine, port B to the host; the read is registered.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells[wr_idx] <= wr_data;
        end
        if (rd_en) begin
            rd_data <= cells[rd_idx];
        end
    end

endmodule

// File: rtl/acq_ring_ptrs.sv
module acq_ring_ptrs #(
    parameter int DEPTH = 2003,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             rear_wr,
    input  logic [IDX_W-1:0] rear_val,
    output logic [IDX_W-1:0] front_q,
    output logic [IDX_W-1:0] rear_q,
    output logic             store_en,
    output logic             overrun,
    output logic [IDX_W-1:0] occupancy
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);
    localparam logic [IDX_W-1:0] DEPTH_V  = IDX_W'(DEPTH);

    logic [IDX_W-1:0] front_nx;

    // The depth need not be a power of two, so the wrap is an explicit compare.
    assign front_nx = (front_q == LAST_IDX) ? '0 : front_q + IDX_W'(1);

    // One slot stays empty so that front == rear always means empty.
    assign overrun  = push && (front_nx == rear_q);
    assign store_en = push && !overrun;

    // Modular difference: front + DEPTH - rear stays below DEPTH when front < rear.
    assign occupancy = (front_q >= rear_q) ? (front_q - rear_q)
                                           : (front_q + DEPTH_V - rear_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            front_q <= '0;
            rear_q  <= '0;
        end else begin
            if (store_en) begin
                front_q <= front_nx;
            end
            if (rear_wr) begin
                rear_q <= rear_val;
            end
        end
    end

endmodule

// File: rtl/acq_ring_irq_ctl.sv
module acq_ring_irq_ctl
    import acq_ring_pkg::*;
#(
    parameter int DEPTH = 2003,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  occupancy,
    input  logic              overrun,
    input  logic              hw_err,
    input  logic [SIDE_W-1:0] side_evt,
    input  logic              thr_wr,
    input  logic [IDX_W-1:0]  thr_val,
    input  logic              mask_wr,
    input  logic [STAT_W-1:0] mask_val,
    input  logic [STAT_W-1:0] stat_clr,
    output logic [IDX_W-1:0]  thr_q,
    output logic [STAT_W-1:0] mask_q,
    output logic [STAT_W-1:0] status_q,
    output logic              irq
);

    localparam logic [IDX_W-1:0] THR_RST = IDX_W'(DEPTH / 2);

    logic [STAT_W-1:0] set_vec;

    always_comb begin
        set_vec                               = '0;
        set_vec[ST_THRESH]                    = (thr_q != '0) && (occupancy >= thr_q);
        set_vec[ST_OVERRUN]                   = overrun;
        set_vec[ST_HW_ERR]                    = hw_err;
        set_vec[ST_SIDE_LO +: SIDE_W]         = side_evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            thr_q    <= THR_RST;
            mask_q   <= '0;
            status_q <= '0;
        end else begin
            if (thr_wr) begin
                thr_q <= thr_val;
            end
            if (mask_wr) begin
                mask_q <= mask_val;
            end
            // Sticky flags: clear by writing ones, a fresh set wins.
            status_q <= (status_q & ~stat_clr) | set_vec;
        end
    end

    assign irq = |(status_q & mask_q);

endmodule

// File: rtl/acq_ring_host.sv
module acq_ring_host
    import acq_ring_pkg::*;
#(
    parameter int DEPTH  = 2003,
    parameter int DATA_W = 16,
    parameter int IDX_W  = $clog2(DEPTH),
    parameter int ADDR_W = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [IDX_W-1:0]  front_q,
    input  logic [IDX_W-1:0]  rear_q,
    input  logic [IDX_W-1:0]  thr_q,
    input  logic [STAT_W-1:0] mask_q,
    input  logic [STAT_W-1:0] status_q,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              host_ready,
    output logic              host_rvalid,
    output logic [DATA_W-1:0] host_rdata,
    output logic              mem_rd_en,
    output logic [IDX_W-1:0]  mem_rd_idx,
    output logic              rear_wr,
    output logic              thr_wr,
    output logic              mask_wr,
    output logic [IDX_W-1:0]  idx_val,
    output logic [STAT_W-1:0] mask_val,
    output logic [STAT_W-1:0] stat_clr
);

    host_state_e       state_q, state_d;
    logic              accept;
    logic              in_window;
    logic              in_regs;
    reg_sel_e          sel;
    logic [DATA_W-1:0] reg_word;
    logic [DATA_W-1:0] reg_word_q;
    logic              from_mem_q;

    assign accept    = host_req && (state_q == H_IDLE);
    assign in_window = host_addr < ADDR_W'(DEPTH);
    assign in_regs   = host_addr[ADDR_W-1] && (host_addr[IDX_W-1:0] <= IDX_W'(4));
    assign sel       = reg_sel_e'(host_addr[2:0]);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= H_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            H_IDLE: if (accept && !host_we) state_d = H_RESP;
            H_RESP: state_d = H_IDLE;
        endcase
    end

    // Outputs of the state machine
    always_comb begin
        unique case (state_q)
            H_IDLE: begin
                host_ready  = 1'b1;
                host_rvalid = 1'b0;
                host_rdata  = '0;
            end
            H_RESP: begin
                host_ready  = 1'b0;
                host_rvalid = 1'b1;
                host_rdata  = from_mem_q ? mem_rdata : reg_word_q;
            end
        endcase
    end

    // Register read multiplexer
    always_comb begin
        reg_word = '0;
        if (in_regs) begin
            unique case (sel)
                REG_FRONT:  reg_word = DATA_W'(front_q);
                REG_REAR:   reg_word = DATA_W'(rear_q);
                REG_THRESH: reg_word = DATA_W'(thr_q);
                REG_MASK:   reg_word = DATA_W'(mask_q);
                REG_STATUS: reg_word = DATA_W'(status_q);
                default:    reg_word = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_word_q <= '0;
            from_mem_q <= 1'b0;
        end else if (accept && !host_we) begin
            reg_word_q <= reg_word;
            from_mem_q <= in_window;
        end
    end

    assign mem_rd_en  = accept && !host_we && in_window;
    assign mem_rd_idx = host_addr[IDX_W-1:0];

    // Write strobes; front and the sample window have no write path.
    assign idx_val  = host_wdata[IDX_W-1:0];
    assign mask_val = host_wdata[STAT_W-1:0];
    assign rear_wr  = accept && host_we && in_regs && (sel == REG_REAR)
                      && (host_wdata < DATA_W'(DEPTH));
    assign thr_wr   = accept && host_we && in_regs && (sel == REG_THRESH);
    assign mask_wr  = accept && host_we && in_regs && (sel == REG_MASK);
    assign stat_clr = (accept && host_we && in_regs && (sel == REG_STATUS))
                      ? host_wdata[STAT_W-1:0] : '0;

endmodule

// File: rtl/acq_ring_top.sv
module acq_ring_top
    import acq_ring_pkg::*;
#(
    parameter int DEPTH  = 2003,
    parameter int DATA_W = 16,
    parameter int IDX_W  = $clog2(DEPTH),
    parameter int ADDR_W = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] smp_data,
    input  logic              in_hw_err,
    input  logic [4:0]        side_evt,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_ready,
    output logic              host_rvalid,
    output logic [DATA_W-1:0] host_rdata,
    output logic              irq
);

    logic [IDX_W-1:0]  front_q, rear_q, occupancy, thr_q, idx_val, mem_rd_idx;
    logic [STAT_W-1:0] mask_q, status_q, mask_val, stat_clr;
    logic [DATA_W-1:0] mem_rdata;
    logic              store_en, overrun, mem_rd_en, rear_wr, thr_wr, mask_wr;

    acq_ring_ptrs #(.DEPTH(DEPTH), .IDX_W(IDX_W)) ptrs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (smp_valid),
        .rear_wr   (rear_wr),
        .rear_val  (idx_val),
        .front_q   (front_q),
        .rear_q    (rear_q),
        .store_en  (store_en),
        .overrun   (overrun),
        .occupancy (occupancy)
    );

    acq_ring_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .IDX_W(IDX_W)) store_i (
        .clk     (clk),
        .wr_en   (store_en),
        .wr_idx  (front_q),
        .wr_data (smp_data),
        .rd_en   (mem_rd_en),
        .rd_idx  (mem_rd_idx),
        .rd_data (mem_rdata)
    );

    acq_ring_irq_ctl #(.DEPTH(DEPTH), .IDX_W(IDX_W)) irq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .occupancy (occupancy),
        .overrun   (overrun),
        .hw_err    (in_hw_err),
        .side_evt  (side_evt),
        .thr_wr    (thr_wr),
        .thr_val   (idx_val),
        .mask_wr   (mask_wr),
        .mask_val  (mask_val),
        .stat_clr  (stat_clr),
        .thr_q     (thr_q),
        .mask_q    (mask_q),
        .status_q  (status_q),
        .irq       (irq)
    );

    acq_ring_host #(.DEPTH(DEPTH), .DATA_W(DATA_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) host_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_req    (host_req),
        .host_we     (host_we),
        .host_addr   (host_addr),
        .host_wdata  (host_wdata),
        .front_q     (front_q),
        .rear_q      (rear_q),
        .thr_q       (thr_q),
        .mask_q      (mask_q),
        .status_q    (status_q),
        .mem_rdata   (mem_rdata),
        .host_ready  (host_ready),
        .host_rvalid (host_rvalid),
        .host_rdata  (host_rdata),
        .mem_rd_en   (mem_rd_en),
        .mem_rd_idx  (mem_rd_idx),
        .rear_wr     (rear_wr),
        .thr_wr      (thr_wr),
        .mask_wr     (mask_wr),
        .idx_val     (idx_val),
        .mask_val    (mask_val),
        .stat_clr    (stat_clr)
    );

endmodule

// File: rtl/acq_ring_chk.sv
module acq_ring_chk #(
    parameter int DEPTH = 2003,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             push,
    input logic [IDX_W-1:0] front,
    input logic [IDX_W-1:0] rear,
    input logic [7:0]       status,
    input logic [7:0]       mask,
    input logic [7:0]       stat_clr,
    input logic             irq,
    input logic             host_req,
    input logic             host_we,
    input logic             host_ready,
    input logic             host_rvalid
);

    logic [IDX_W-1:0] nxt;
    assign nxt = (int'(front) == DEPTH - 1) ? '0 : front + IDX_W'(1);

    // R2
    front_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && (nxt != rear)) |=> (front == $past(nxt)));

    // R3
    overrun_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && (nxt == rear)) |=> (status[1] && (front == $past(front))));

    // R5
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(front) < DEPTH) && (int'(rear) < DEPTH));

    // R8
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr == '0) |=> ((status & $past(status)) == $past(status)));

    // R9
    mask_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq);

    // R4
    read_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && host_ready && !host_we) |=> host_rvalid);

    // R10
    resp_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_rvalid |=> !host_rvalid);

    // R10
    resp_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_rvalid |-> !host_ready);

endmodule

bind acq_ring_top acq_ring_chk #(.DEPTH(DEPTH), .IDX_W(IDX_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .push        (smp_valid),
    .front       (front_q),
    .rear        (rear_q),
    .status      (status_q),
    .mask        (mask_q),
    .stat_clr    (stat_clr),
    .irq         (irq),
    .host_req    (host_req),
    .host_we     (host_we),
    .host_ready  (host_ready),
    .host_rvalid (host_rvalid)
);

// File: tb/acq_ring_top_tb_top.sv
module acq_ring_top_tb_top;

    localparam int D  = 13;
    localparam int DW = 16;
    localparam int IW = $clog2(D);
    localparam int AW = IW + 1;
    localparam int RB = 1 << IW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          smp_valid;
    logic [DW-1:0] smp_data;
    logic          in_hw_err;
    logic [4:0]    side_evt;
    logic          host_req, host_we;
    logic [AW-1:0] host_addr;
    logic [DW-1:0] host_wdata;
    logic          host_ready, host_rvalid, irq;
    logic [DW-1:0] host_rdata;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    always #10 clk = ~clk;

    acq_ring_top #(.DEPTH(D), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .in_hw_err(in_hw_err), .side_evt(side_evt), .host_req(host_req),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_ready(host_ready), .host_rvalid(host_rvalid),
        .host_rdata(host_rdata), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Reference model: integers and arrays, advanced on every rising edge.
    int            m_front = 0, m_rear = 0, m_thr = D / 2, m_mask = 0, m_stat = 0;
    bit            m_resp = 0, m_rknown = 0;
    int            m_rdata = 0;
    logic [DW-1:0] m_mem  [D];
    bit            m_memv [D];

    always @(posedge clk) begin : ref_model
        int occ, nf, setv, clr, nfront, nrear, a;
        if (!rst_n) begin
            m_front = 0; m_rear = 0; m_thr = D / 2; m_mask = 0; m_stat = 0;
            m_resp = 0;
        end else begin
            occ    = (m_front >= m_rear) ? m_front - m_rear : m_front + D - m_rear;
            setv   = 0;
            clr    = 0;
            nfront = m_front;
            nrear  = m_rear;
            a      = int'(host_addr);
            if (m_thr != 0 && occ >= m_thr) setv |= 1;
            if (m_resp) begin
                m_resp = 0;
            end else if (host_req) begin
                if (host_we) begin
                    if (a == RB + 1 && int'(host_wdata) < D) nrear = int'(host_wdata);
                    if (a == RB + 2) m_thr = int'(host_wdata) % RB;
                    if (a == RB + 3) m_mask = int'(host_wdata) & 8'hFF;
                    if (a == RB + 4) clr = int'(host_wdata) & 8'hFF;
                end else begin
                    m_resp   = 1;
                    m_rknown = 1;
                    m_rdata  = 0;
                    if (a < D) begin
                        m_rknown = m_memv[a];
                        m_rdata  = int'(m_mem[a]);
                    end
                    else if (a == RB)     m_rdata = m_front;
                    else if (a == RB + 1) m_rdata = m_rear;
                    else if (a == RB + 2) m_rdata = m_thr;
                    else if (a == RB + 3) m_rdata = m_mask;
                    else if (a == RB + 4) m_rdata = m_stat;
                end
            end
            nf = (m_front + 1 == D) ? 0 : m_front + 1;
            if (smp_valid) begin
                if (nf == m_rear) setv |= 2;
                else begin
                    m_mem[m_front]  = smp_data;
                    m_memv[m_front] = 1;
                    nfront = nf;
                end
            end
            if (in_hw_err) setv |= 4;
            setv |= int'(side_evt) << 3;
            m_stat  = (m_stat & ~clr) | setv;
            m_front = nfront;
            m_rear  = nrear;
        end
    end

    // Per-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R9 irq vs model", 32'(irq), 32'(((m_stat & m_mask) != 0)));
            chk("R10 ready vs model", 32'(host_ready), 32'(!m_resp));
            chk("R10 rvalid vs model", 32'(host_rvalid), 32'(m_resp));
            if (m_resp && m_rknown) chk("R4 rdata vs model", 32'(host_rdata), 32'(m_rdata));
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 20000) begin
            n_fail++;
            $display("FAIL R10 watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic wr(input int a, input int v);
        @(negedge clk);
        host_req = 1'b1; host_we = 1'b1; host_addr = AW'(a); host_wdata = DW'(v);
        @(negedge clk);
        host_req = 1'b0; host_we = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input int a, input int exp);
        @(negedge clk);
        host_req = 1'b1; host_we = 1'b0; host_addr = AW'(a);
        @(negedge clk);
        host_req = 1'b0;
        chk("R10 response cycle ready/rvalid", {30'd0, host_rvalid, host_ready}, 32'b10);
        chk(tag, 32'(host_rdata), 32'(exp));
    endtask

    task automatic push_run(input int n, input int base);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            smp_valid = 1'b1; smp_data = DW'(base + i);
        end
        @(negedge clk);
        smp_valid = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0; smp_valid = 1'b0; smp_data = '0; in_hw_err = 1'b0;
        side_evt = '0; host_req = 1'b0; host_we = 1'b0; host_addr = '0; host_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 irq low after reset", 32'(irq), 32'd0);
        rd_chk("R1 front reset", RB, 0);
        rd_chk("R1 rear reset", RB + 1, 0);
        rd_chk("R1 threshold reset", RB + 2, D / 2);
        rd_chk("R1 mask reset", RB + 3, 0);
        rd_chk("R1 status reset", RB + 4, 0);

        // R2 pushes land in order; R6 threshold at occupancy 6
        push_run(5, 'h100);
        rd_chk("R6 below threshold no flag", RB + 4, 0);
        push_run(1, 'h105);
        for (int i = 0; i < 5; i++) rd_chk("R2 stored sample", i, 'h100 + i);
        rd_chk("R2 front after six pushes", RB, 6);
        rd_chk("R6 threshold flag set", RB + 4, 1);
        chk("R9 masked flag keeps irq low", 32'(irq), 32'd0);

        // R9 unmask; R8 set beats clear
        wr(RB + 3, 1);
        chk("R9 irq on when unmasked", 32'(irq), 32'd1);
        wr(RB + 4, 1);
        rd_chk("R8 set wins over clear", RB + 4, 1);

        // Host drains; R8 clear then
        wr(RB + 1, 6);
        wr(RB + 4, 1);
        rd_chk("R8 cleared by write one", RB + 4, 0);
        chk("R9 irq off after clear", 32'(irq), 32'd0);

        // R5 ignored writes
        wr(RB + 1, D);
        rd_chk("R5 rear out of range ignored", RB + 1, 6);
        wr(RB, 3);
        rd_chk("R5 front not writable", RB, 6);
        wr(0, 'hDEAD);
        rd_chk("R5 sample window not writable", 0, 'h100);

        // R6 disable, R2 wrap, R3 overrun
        wr(RB + 2, 0);
        push_run(12, 'h200);
        rd_chk("R6 zero threshold never flags", RB + 4, 0);
        rd_chk("R2 front wrapped", RB, 5);
        rd_chk("R2 sample at wrapped slot 0", 0, 'h207);
        push_run(1, 'h2FF);
        rd_chk("R3 overrun front unchanged", RB, 5);
        rd_chk("R3 overrun slot unchanged", 5, 'h105);
        rd_chk("R3 overrun flag", RB + 4, 2);

        // R7 event inputs
        @(negedge clk); in_hw_err = 1'b1; side_evt = 5'h1F;
        @(negedge clk); in_hw_err = 1'b0; side_evt = 5'h00;
        rd_chk("R7 hw error and side events", RB + 4, 'hFE);
        wr(RB + 3, 'h80);
        chk("R9 command-done bit drives irq", 32'(irq), 32'd1);
        wr(RB + 3, 0);
        chk("R9 zero mask holds irq low", 32'(irq), 32'd0);
        wr(RB + 4, 'hFF);
        rd_chk("R8 all flags cleared", RB + 4, 0);

        // R4 unmapped addresses
        rd_chk("R4 gap address reads zero", D + 1, 0);
        rd_chk("R4 unused register reads zero", RB + 5, 0);
        rd_chk("R4 top address reads zero", RB + 7, 0);

        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule